// File: doc/BRIEF.md
# Processor Core Reset Sequencer

This block produces the active-low reset for a processor core. Two platform inputs feed it: a power-good level and an active-low upstream reset. Reset is forced low at once whenever either input reports that the system is not ready. When both inputs are ready, the block passes the readiness through a two-flop synchronizer and then holds reset for a programmed number of reference-clock cycles. It also waits for the core PLL to report lock before it lets reset go.

The power-good level already guarantees that the supply has settled, so the block adds no settling delay of its own. The hold length, `HOLD_CYC`, is a parameter in reference-clock cycles. It must lie between one and ten milliseconds, measured with `TICKS_PER_MS` cycles per millisecond, and elaboration fails if it does not. If lock has not arrived at the ten-millisecond limit, a sticky timeout flag rises and reset stays asserted.

For the whole time reset is low, a configuration register is driven onto a strap bus, so the core can capture its power-on options. The register can only be loaded while the sequencer is idle, that is, before the hold interval starts.

Top module: `core_reset_seq`

## Requirements
- R1: While `pwr_ok` is low, `core_rst_n` is low. When `pwr_ok` falls, `core_rst_n` falls without waiting for a clock edge.
- R2: While `plat_rst_n` is low, `core_rst_n` is low. When `plat_rst_n` falls, `core_rst_n` falls without waiting for a clock edge.
- R3: Count the clock edges after both inputs go high, the first such edge being number 1. If `pll_lock` is already high, `core_rst_n` rises at edge 3+`HOLD_CYC`.
- R4: `core_rst_n` never rises before lock has been seen. If `pll_lock` is first sampled high at edge L, `core_rst_n` rises at edge max(3+`HOLD_CYC`, L+2), provided that edge is not later than 3+10·`TICKS_PER_MS`.
- R5: If no release has happened by edge 3+10·`TICKS_PER_MS`, `timeout_err` goes high at that edge. From then on, `timeout_err` stays high and `core_rst_n` stays low, even if lock arrives later, until the next restart.
- R6: A low on either input during the sequence restarts it. The restart clears the hold count and `timeout_err`, and the next release again takes the full delay of R3/R4.
- R7: While `core_rst_n` is low, `strap_oe` is 1 and `strap_out` equals the configuration register. While `core_rst_n` is high, `strap_oe` is 0 and `strap_out` is all zeros.
- R8: A write (`cfg_we` high at a clock edge) loads `cfg_wdata` only while the sequencer is idle. Idle means `pwr_ok` is high and the hold interval has not yet begun, for example while `plat_rst_n` is low. Writes during the hold, after a timeout or after release are ignored.
- R9: While `pwr_ok` is low, the configuration register reads `CFG_INIT`. The register keeps its value across cycles of `plat_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| pwr_ok | input | 1 | Platform power-good, asynchronous, active high |
| plat_rst_n | input | 1 | Upstream platform reset, asynchronous, active low |
| pll_lock | input | 1 | Core PLL lock indication, asynchronous |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | STRAP_W | Configuration write data |
| core_rst_n | output | 1 | Core reset, active low, driven from a flop |
| strap_oe | output | 1 | Strap bus drive enable |
| strap_out | output | STRAP_W | Power-on strap values |
| timeout_err | output | 1 | Sticky flag: lock missed the maximum window |

## Verification
The bench places lock arrival at the edge just before the minimum-hold release, at the edge that makes release land exactly on the ten-millisecond limit, and one edge beyond that limit. A design with the priority between release and timeout reversed, or with an off-by-one counter, would flag a timeout or release one cycle early or late at these points. The bench also drops the upstream reset part-way through a hold and checks that the next release again takes the full delay; a counter that is not cleared on restart would release too soon. Writes issued during the hold and after release must leave the straps unchanged across a later reset, and a power loss must bring the straps back to their initial value. A register that accepted late writes or survived the power loss would show the wrong strap word.

// File: rtl/core_reset_seq.sv
module core_reset_seq #(
  parameter int unsigned        TICKS_PER_MS = 125000,
  parameter int unsigned        HOLD_CYC     = 250000,
  parameter int unsigned        STRAP_W      = 16,
  parameter logic [STRAP_W-1:0] CFG_INIT     = '0
) (
  input  logic               clk,
  input  logic               pwr_ok,
  input  logic               plat_rst_n,
  input  logic               pll_lock,
  input  logic               cfg_we,
  input  logic [STRAP_W-1:0] cfg_wdata,
  output logic               core_rst_n,
  output logic               strap_oe,
  output logic [STRAP_W-1:0] strap_out,
  output logic               timeout_err
);

  localparam int unsigned    MIN_CYC   = TICKS_PER_MS;
  localparam int unsigned    MAX_CYC   = 10 * TICKS_PER_MS;
  localparam int             CW        = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0]  HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0]  MAX_LAST  = CW'(MAX_CYC - 1);

  if (HOLD_CYC < MIN_CYC || HOLD_CYC > MAX_CYC) begin : g_hold_range_bad
    $error("core_reset_seq: HOLD_CYC outside the 1 ms to 10 ms window");
  end

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_RUN, ST_TMO} seq_st_t;

  logic               arst_n;
  logic [1:0]         rdy_sync;
  logic [1:0]         lock_sync;
  seq_st_t            st;
  logic [CW-1:0]      cnt;
  logic [STRAP_W-1:0] cfg_q;

  assign arst_n = pwr_ok & plat_rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rdy_sync  <= '0;
      lock_sync <= '0;
    end else begin
      rdy_sync  <= {rdy_sync[0], 1'b1};
      lock_sync <= {lock_sync[0], pll_lock};
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      core_rst_n  <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (rdy_sync[1]) begin
          st  <= ST_HOLD;
          cnt <= '0;
        end
        ST_HOLD: begin
          if (cnt >= HOLD_LAST && lock_sync[1]) begin
            st         <= ST_RUN;
            core_rst_n <= 1'b1;
          end else if (cnt == MAX_LAST) begin
            st          <= ST_TMO;
            timeout_err <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)                     cfg_q <= CFG_INIT;
    else if (cfg_we && st == ST_IDLE) cfg_q <= cfg_wdata;
  end

  assign strap_oe  = ~core_rst_n;
  assign strap_out = core_rst_n ? '0 : cfg_q;

  logic [CW:0] since_rdy;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                       since_rdy <= '0;
    else if (since_rdy != {(CW+1){1'b1}}) since_rdy <= since_rdy + 1'b1;
  end

  always @(negedge clk) begin
    if (!pwr_ok)     AST_PWR_DOWN_HOLDS: assert (!core_rst_n);     // R1
    if (!plat_rst_n) AST_PLAT_RST_HOLDS: assert (!core_rst_n);     // R2
  end

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst_n) |-> since_rdy >= (CW+1)'(MIN_CYC + 3));    // R3
  AST_MAX_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst_n) |-> since_rdy <= (CW+1)'(MAX_CYC + 3));    // R4
  AST_LOCK_SEEN: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_rst_n) |-> $past(pll_lock, 3));                   // R4
  AST_TMO_AT_LIMIT: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(timeout_err) |-> since_rdy == (CW+1)'(MAX_CYC + 3));   // R5
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    timeout_err |=> timeout_err && !core_rst_n);                 // R5
  AST_STRAP_STABLE: assert property (@(posedge clk) disable iff (!arst_n)
    (st != ST_IDLE && !core_rst_n) |=> (core_rst_n || $stable(strap_out))); // R8

endmodule

// File: tb/sim_core_reset_seq.sv
module sim_core_reset_seq;
  localparam int unsigned TPM  = 20;
  localparam int unsigned HOLD = 40;
  localparam int unsigned MAXC = 10 * TPM;
  localparam int unsigned W    = 8;
  localparam logic [W-1:0] INIT = 8'hA5;

  logic clk = 1'b0;
  logic pwr_ok, plat_rst_n, pll_lock, cfg_we;
  logic [W-1:0] cfg_wdata;
  logic core_rst_n, strap_oe, timeout_err;
  logic [W-1:0] strap_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [W-1:0] cfg_model;

  always #4 clk = ~clk;

  core_reset_seq #(.TICKS_PER_MS(TPM), .HOLD_CYC(HOLD), .STRAP_W(W), .CFG_INIT(INIT)) u0 (
    .clk(clk), .pwr_ok(pwr_ok), .plat_rst_n(plat_rst_n), .pll_lock(pll_lock),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .core_rst_n(core_rst_n),
    .strap_oe(strap_oe), .strap_out(strap_out), .timeout_err(timeout_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_release(input int lock_at);
    int r;
    r = 3 + HOLD;
    if (lock_at + 2 > r) r = lock_at + 2;
    if (r > 3 + MAXC) r = -1;
    return r;
  endfunction

  task automatic check_straps(input bit rel, input string req);
    chk(strap_oe == !rel, req, 32'(strap_oe), 32'(!rel));
    chk(strap_out == (rel ? '0 : cfg_model), req, 32'(strap_out), 32'(rel ? '0 : cfg_model));
  endtask

  task automatic enter_reset_plat();
    @(negedge clk);
    #1 plat_rst_n = 1'b0; pll_lock = 1'b0; cfg_we = 1'b0;
    #1 chk(core_rst_n == 1'b0, "R2", 32'(core_rst_n), 0);
    check_straps(1'b0, "R9");
    @(negedge clk);
    chk(timeout_err == 1'b0, "R6", 32'(timeout_err), 0);
  endtask

  task automatic write_cfg(input logic [W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_model = v;
    chk(strap_out == v, "R8", 32'(strap_out), 32'(v));
  endtask

  task automatic run_seq(input int lock_at, input int abort_at, input int wr_at, input string rtag);
    int rel, last;
    bit er, et;
    rel  = exp_release(lock_at);
    last = (rel < 0) ? 3 + MAXC + 3 : rel + 3;
    pll_lock   = (lock_at <= 1);
    plat_rst_n = 1'b1;
    for (int e = 1; e <= last; e++) begin
      @(posedge clk); @(negedge clk);
      er = (rel > 0 && e >= rel);
      et = (rel < 0 && e >= 3 + MAXC);
      chk(core_rst_n == er, (rel < 0) ? "R5" : rtag, 32'(core_rst_n), 32'(er));
      chk(timeout_err == et, "R5", 32'(timeout_err), 32'(et));
      check_straps(er, (wr_at > 0 && e > wr_at) ? "R8" : "R7");
      if (abort_at > 0 && e == abort_at) begin
        cfg_we = 1'b0;
        return;
      end
      if (e + 1 == lock_at) pll_lock = 1'b1;
      if (e == wr_at) begin
        cfg_we = 1'b1; cfg_wdata = ~cfg_model;
      end else begin
        cfg_we = 1'b0;
      end
    end
    cfg_we = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", 32'(cyc), 150000);
      report();
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    pwr_ok = 1'b0; plat_rst_n = 1'b0; pll_lock = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    cfg_model = INIT;
    repeat (3) @(negedge clk);
    chk(core_rst_n == 1'b0, "R1", 32'(core_rst_n), 0);
    chk(timeout_err == 1'b0, "R5", 32'(timeout_err), 0);
    check_straps(1'b0, "R7");

    // R9: write while power is down is lost in the held register
    cfg_we = 1'b1; cfg_wdata = 8'h11;
    @(negedge clk); cfg_we = 1'b0;
    chk(strap_out == INIT, "R9", 32'(strap_out), 32'(INIT));

    pwr_ok = 1'b1;
    @(negedge clk);
    chk(core_rst_n == 1'b0, "R2", 32'(core_rst_n), 0);
    write_cfg(8'h3C);

    run_seq(1, 0, 0, "R3");
    // R8: write after release ignored, visible after next reset
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'hC3;
    @(negedge clk); cfg_we = 1'b0;
    check_straps(1'b1, "R7");
    enter_reset_plat();
    chk(strap_out == 8'h3C, "R8", 32'(strap_out), 32'h3C);

    run_seq(3 + HOLD - 2, 0, 0, "R3");
    enter_reset_plat();
    run_seq(3 + HOLD + 10, 0, 0, "R4");
    enter_reset_plat();
    run_seq(3 + MAXC - 2, 0, 0, "R4");
    enter_reset_plat();
    run_seq(3 + MAXC - 1, 0, 0, "R5");
    enter_reset_plat();
    run_seq(3 + MAXC + 20, 0, 0, "R5");
    enter_reset_plat();

    // R6: restart in mid-hold takes the full delay again
    run_seq(1, 20, 0, "R6");
    enter_reset_plat();
    run_seq(1, 0, 0, "R6");
    enter_reset_plat();

    // R8: write during hold ignored
    run_seq(1, 0, 10, "R3");

    // R1: power loss while running
    @(negedge clk);
    #1 pwr_ok = 1'b0;
    #1 chk(core_rst_n == 1'b0, "R1", 32'(core_rst_n), 0);
    chk(strap_out == INIT, "R9", 32'(strap_out), 32'(INIT));
    cfg_model = INIT;
    plat_rst_n = 1'b0;
    @(negedge clk); pwr_ok = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      int la, wa;
      write_cfg(W'($urandom));
      la = 1 + int'($urandom % (3 + MAXC + 8));
      wa = (($urandom % 2) == 0) ? 0 : 5 + int'($urandom % 30);
      run_seq(la, 0, wa, (la + 2 > 3 + HOLD) ? "R4" : "R3");
      enter_reset_plat();
    end
    report();
  end
endmodule